// File: doc/BRIEF.md
# Three-Multiplier Complex Multiply-Accumulate

This unit multiplies a stream of complex samples by complex coefficients and keeps a running complex sum of the products. Each cycle it may accept a sample `P + jQ` and a coefficient `R + jS`. All four values are in sign-magnitude form. The output is a pair of two's complement accumulators holding the running sum of `PR − QS` (real) and `PS + QR` (imaginary). It is intended as the arithmetic core of a complex FIR tap loop. Coefficient storage and the sample delay line belong to the surrounding logic.

The product uses three multipliers instead of four. Stage one converts the operands to two's complement and forms the pre-terms `P−Q`, `R−S` and `R+S`, each one bit wider than an operand so that none can overflow. Stage two forms three products:
- the shared product `(P−Q)·S`;
- the real-path product `(R−S)·P`;
- the imaginary-path product `Q·(R+S)`.

Stage three does the accumulation. Each path adds its own product to its running sum, or to zero when a clear travels with the sample. It then adds the shared product in the same cycle. No separate accumulator adder follows the multipliers.

Top module: `cmac3`

## Requirements
- R1: Each operand is W bits: bit W-1 is the sign (1 = negative) and bits W-2..0 the magnitude; a negative zero (sign 1, magnitude 0) acts exactly as zero.
- R2: For each accepted sample, `acc_re` grows by P·R − Q·S.
- R3: For each accepted sample, `acc_im` grows by P·S + Q·R.
- R4: Both accumulators are AW-bit two's complement values that wrap modulo 2^AW on overflow.
- R5: `out_valid` is high exactly three cycles after a cycle with `in_valid` high, and never otherwise. The accumulators then already include that sample.
- R6: A sample given with `clr` high restarts both sums: three cycles later the outputs equal that sample's product alone.
- R7: `clr` high with `in_valid` low sets both accumulators to zero three cycles later, with `out_valid` staying low.
- R8: A cycle with neither `in_valid` nor `clr` leaves both accumulators unchanged.
- R9: While `rst` is high, `out_valid` is low and both accumulators are zero.
- R10: Samples on consecutive cycles are all accumulated with no bubbles and no lost terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| clr | input | 1 | Restart both accumulators |
| p_in | input | W | Sample real part, sign-magnitude |
| q_in | input | W | Sample imaginary part, sign-magnitude |
| r_in | input | W | Coefficient real part, sign-magnitude |
| s_in | input | W | Coefficient imaginary part, sign-magnitude |
| out_valid | output | 1 | Accumulators just absorbed a sample |
| acc_re | output | AW | Real running sum, two's complement |
| acc_im | output | AW | Imaginary running sum, two's complement |

## Verification
The only state is the two accumulators and the short pipeline in front of them. A wrong product term or a mishandled sign would show at the ports three cycles after the sample that caused it. The error would then persist in every later output until the next clear. A clear or valid that slips a stage shows as a valid pulse at the wrong cycle, or as a sum that absorbed a neighbouring sample. For that reason every output is compared in the cycle it appears. The comparison is against a four-multiplier integer model, over long random runs with clears mixed in, and over bursts long enough to wrap the accumulators.

// File: rtl/cmac3.sv
module cmac3 #(
  parameter int W  = 8,
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 clr,
  input  logic [W-1:0]         p_in,
  input  logic [W-1:0]         q_in,
  input  logic [W-1:0]         r_in,
  input  logic [W-1:0]         s_in,
  output logic                 out_valid,
  output logic signed [AW-1:0] acc_re,
  output logic signed [AW-1:0] acc_im
);
  localparam int PW = W + 1;
  localparam int MW = PW + W;

  function automatic logic signed [W-1:0] to_tc(input logic [W-1:0] x);
    logic signed [W-1:0] m;
    m = signed'({1'b0, x[W-2:0]});
    return x[W-1] ? -m : m;
  endfunction

  logic signed [W-1:0] sp, sq, sr, ss;
  assign sp = to_tc(p_in);
  assign sq = to_tc(q_in);
  assign sr = to_tc(r_in);
  assign ss = to_tc(s_in);

  // stage 1: pre-terms
  logic signed [PW-1:0] d_pq, d_rs, a_rs;
  logic signed [W-1:0]  p1, q1, s1;
  logic                 v1, c1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      c1 <= 1'b0;
    end else begin
      v1 <= in_valid;
      c1 <= clr;
    end
    d_pq <= PW'(sp) - PW'(sq);
    d_rs <= PW'(sr) - PW'(ss);
    a_rs <= PW'(sr) + PW'(ss);
    p1   <= sp;
    q1   <= sq;
    s1   <= ss;
  end

  // stage 2: shared product and the two path products
  logic signed [MW-1:0] m_sh, m_re, m_im;
  logic                 v2, c2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0;
      c2 <= 1'b0;
    end else begin
      v2 <= v1;
      c2 <= c1;
    end
    m_sh <= MW'(d_pq) * MW'(s1);
    m_re <= MW'(d_rs) * MW'(p1);
    m_im <= MW'(q1)   * MW'(a_rs);
  end

  // stage 3: fused accumulate plus shared term
  logic signed [AW-1:0] base_re, base_im, nxt_re, nxt_im;
  assign base_re = c2 ? '0 : acc_re;
  assign base_im = c2 ? '0 : acc_im;
  assign nxt_re  = base_re + AW'(m_re) + AW'(m_sh);
  assign nxt_im  = base_im + AW'(m_im) + AW'(m_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_re    <= '0;
      acc_im    <= '0;
    end else begin
      out_valid <= v2;
      if (v2) begin
        acc_re <= nxt_re;
        acc_im <= nxt_im;
      end else if (c2) begin
        acc_re <= '0;
        acc_im <= '0;
      end
    end
  end
endmodule

// File: rtl/cmac3_chk.sv
module cmac3_chk #(
  parameter int AW = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 clr,
  input logic                 out_valid,
  input logic signed [AW-1:0] acc_re,
  input logic signed [AW-1:0] acc_im
);
  logic [1:0] age;
  logic       rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R5
  a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R7
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(clr, 3) && !$past(in_valid, 3)) |-> (acc_re == '0 && acc_im == '0 && !out_valid));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(in_valid, 3) && !$past(clr, 3)) |-> ($stable(acc_re) && $stable(acc_im)));

  // R9
  a_r9_reset_state: assert property (@(posedge clk)
    rst_q |-> (!out_valid && acc_re == '0 && acc_im == '0));
endmodule

bind cmac3 cmac3_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .clr(clr),
  .out_valid(out_valid), .acc_re(acc_re), .acc_im(acc_im)
);

// File: tb/sim_cmac3.sv
module sim_cmac3;
  localparam int W  = 8;
  localparam int AW = 24;
  localparam int MX = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, clr = 1'b0;
  logic [W-1:0] p_in = '0, q_in = '0, r_in = '0, s_in = '0;
  logic out_valid;
  logic signed [AW-1:0] acc_re, acc_im;

  always #2 clk = ~clk;

  cmac3 #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .clr(clr),
    .p_in(p_in), .q_in(q_in), .r_in(r_in), .s_in(s_in),
    .out_valid(out_valid), .acc_re(acc_re), .acc_im(acc_im)
  );

  int checks = 0, errors = 0;
  string tag = "R9";
  logic signed [AW-1:0] m_re = '0, m_im = '0;
  logic signed [AW-1:0] q_re[$], q_im[$];

  function automatic logic [W-1:0] enc(input int v);
    return v < 0 ? {1'b1, (W-1)'(-v)} : {1'b0, (W-1)'(v)};
  endfunction

  function automatic int dec(input logic [W-1:0] x);
    int m;
    m = int'(x[W-2:0]);
    return x[W-1] ? -m : m;
  endfunction

  task automatic chk(input string t, input logic signed [AW-1:0] act, input logic signed [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] p, q, r, s, input bit v, input bit c);
    @(negedge clk);
    p_in = p; q_in = q; r_in = r; s_in = s;
    in_valid = v; clr = c;
    if (c) begin m_re = '0; m_im = '0; end
    if (v) begin
      m_re = m_re + AW'(dec(p) * dec(r) - dec(q) * dec(s));
      m_im = m_im + AW'(dec(p) * dec(s) + dec(q) * dec(r));
      q_re.push_back(m_re);
      q_im.push_back(m_im);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send('0, '0, '0, '0, 1'b0, 1'b0);
  endtask

  function automatic logic [W-1:0] rnd();
    return enc(int'($urandom_range(2 * MX, 0)) - MX);
  endfunction

  // monitor: compare every produced result against the scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_re.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: actual=unexpected out_valid expected=none");
      end else begin
        chk({tag, " re"}, acc_re, q_re.pop_front());
        chk({tag, " im"}, acc_im, q_im.pop_front());
      end
    end
  end

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 valid", AW'(out_valid), '0);
    chk("R9 re", acc_re, '0);
    chk("R9 im", acc_im, '0);
    @(negedge clk); rst = 1'b0;

    // R2 R3 R10: restart then back-to-back random samples
    tag = "R2/R3/R10";
    send(rnd(), rnd(), rnd(), rnd(), 1'b1, 1'b1);
    for (int i = 0; i < 40; i++) send(rnd(), rnd(), rnd(), rnd(), 1'b1, 1'b0);

    // R1: negative zero behaves as zero
    tag = "R1";
    send({1'b1, (W-1)'(0)}, enc(5), enc(-7), {1'b1, (W-1)'(0)}, 1'b1, 1'b0);
    send(enc(3), {1'b1, (W-1)'(0)}, {1'b1, (W-1)'(0)}, enc(-9), 1'b1, 1'b0);

    // R8: idle cycles hold the sum
    tag = "R8";
    idle(10);
    chk("R8 re", acc_re, m_re);
    chk("R8 im", acc_im, m_im);

    // R6: clear together with a sample
    tag = "R6";
    send(enc(-11), enc(13), enc(17), enc(-19), 1'b1, 1'b1);
    idle(4);
    chk("R6 re", acc_re, AW'(-11 * 17 - 13 * -19));
    chk("R6 im", acc_im, AW'(-11 * -19 + 13 * 17));

    // R7: clear alone zeroes the sums, no valid
    tag = "R7";
    send(rnd(), rnd(), rnd(), rnd(), 1'b0, 1'b1);
    idle(4);
    chk("R7 re", acc_re, '0);
    chk("R7 im", acc_im, '0);

    // R4 R10: long bursts of extreme products wrap the sums
    tag = "R4/R10";
    send(enc(MX), enc(-MX), enc(MX), enc(MX), 1'b1, 1'b1);
    for (int i = 0; i < 600; i++) send(enc(MX), enc(-MX), enc(MX), enc(MX), 1'b1, 1'b0);
    for (int i = 0; i < 600; i++) send(enc(-MX), enc(-MX), enc(MX), enc(-MX), 1'b1, 1'b0);
    for (int i = 0; i < 600; i++) send(enc(MX), enc(MX), enc(-MX), enc(MX), 1'b1, 1'b0);

    // mixed random traffic with gaps and clears (R2 R3 R5 R6 R7 R8)
    tag = "R2/R3/R5 mix";
    for (int i = 0; i < 4000; i++)
      send(rnd(), rnd(), rnd(), rnd(), $urandom_range(9, 0) < 8, $urandom_range(19, 0) == 0);
    idle(8);
    chk("R8 final re", acc_re, m_re);
    chk("R8 final im", acc_im, m_im);
    // R5: every sample produced exactly one result
    chk("R5 pending", AW'(q_re.size()), '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule